// File: doc/BRIEF.md
# Five-Level Page Table Walker

This block translates a 57-bit virtual address into a 52-bit physical address by walking a radix tree of translation tables kept in memory. There are five tiers in the tree. Every table has 512 eight-byte entries. The walk begins at a root table base held in a protected register. At each tier the walker reads one entry at the table base plus eight times a 9-bit slice of the virtual address. It then either continues with the 40-bit pointer found in that entry or stops with a fault.

A requester hands over a virtual address together with two flags: whether the access is a write, and whether it comes from unprivileged (user) code. The walker issues its reads one at a time over a valid/ready read channel and receives entries over a valid/ready response channel. It returns one result per walk:
- on success, the physical address, the write and user rights combined across all tiers, and the dirty flag of the leaf entry;
- on failure, a fault flag and the tier at which the walk stopped.

Caching of translations and the handling of faults are left to surrounding logic.

Top module: `va_walk_engine`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: The first read of a walk goes to the root base. Tiers are visited from 4 (virtual address bits [56:48]) down to 0 (bits [20:12]). The read address at tier L is {table base, va[12+9L+8 : 12+9L], 3'b000}. Each next table base is bits [51:12] of the entry just read.
- R3: At most one read is in flight. No new read request is raised until the response to the previous one has arrived. A walk with no fault makes exactly five reads.
- R4: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` does not change.
- R5: Entry bit 0 is the present flag. An entry with bit 0 clear at tier L ends the walk with `res_fault`=1 and `res_fault_level`=L, and no further reads are made.
- R6: Entry bit 1 grants write. It is ANDed over all five tiers. A write request faults at level 0 after the fifth read if any tier lacks write. A read request through the same tables succeeds and reports `res_writable`=0.
- R7: Entry bit 2 grants user access. It is ANDed over all five tiers. A user request faults at level 0 if any tier lacks it. A supervisor request succeeds and reports `res_user`=0.
- R8: On success, `res_pa` = {leaf entry bits [51:12], va[11:0]}, `res_fault`=0, and `res_dirty` equals bit 6 of the leaf entry.
- R9: A result stays valid and unchanged until `res_ready` is high. After it is taken, `req_ready` is 1 on the next cycle.
- R10: `req_ready` is 0 for the whole of a walk, so a request presented during a walk is ignored and does not change the walk in progress.
- R11: The root base changes only when `root_wr_en` and `root_wr_priv` are both 1. A write with `root_wr_priv`=0 leaves the root unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr_en | input | 1 | Root base write strobe |
| root_wr_priv | input | 1 | Write comes from privileged code |
| root_wr_base | input | 40 | New root table base |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 57 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user code |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_pa | output | 52 | Physical address (0 on fault) |
| res_writable | output | 1 | Combined write right |
| res_user | output | 1 | Combined user right |
| res_dirty | output | 1 | Dirty flag of the leaf entry |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_level | output | 3 | Tier where the walk stopped |

## Verification
The hardest case to reach is a rights violation that lies in an intermediate tier. It only shows at the very end of the walk, after all five reads, even though every single entry looks valid. The bench builds the whole chain of tables in a memory model and clears a single write or user bit at tier 3 or tier 1. It then issues the same address once with the conflicting request flag set and once with it clear. Two further sequences drive the walker's timing. A second request is held on the request port while a walk is in flight. The memory model also stalls its request-ready and delays its responses, so the read handshake is exercised under back-pressure.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int VA_W        = 57;
    localparam int OFF_W       = 12;
    localparam int IDX_W       = 9;
    localparam int LEVELS      = 5;
    localparam int BASE_W      = 40;
    localparam int ENTRY_W     = 64;
    localparam int PA_W        = BASE_W + OFF_W;
    localparam int LVL_W       = $clog2(LEVELS);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);
    localparam int VPN_W       = VA_W - OFF_W;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_DIRTY   = 6;
    localparam int BASE_LSB    = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_NEXT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              present;
        logic              writable;
        logic              user_ok;
        logic              dirty;
    } entry_view_t;

    typedef struct packed {
        walk_state_e        state;
        logic [VA_W-1:0]    va;
        logic               want_w;
        logic               want_u;
        logic [BASE_W-1:0]  base;
        logic [LVL_W-1:0]   level;
        logic               acc_w;
        logic               acc_u;
        logic [ENTRY_W-1:0] entry;
        logic [PA_W-1:0]    pa;
        logic               dirty;
        logic [LVL_W-1:0]   flevel;
    } walk_regs_t;
endpackage

// File: rtl/walk_root_reg.sv
module walk_root_reg
    import walk_pkg::*;
#(
    parameter logic [BASE_W-1:0] RESET_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [BASE_W-1:0] wr_base,
    output logic [BASE_W-1:0] root_base
);
    logic [BASE_W-1:0] root_d, root_q;

    always_comb begin
        root_d = root_q;
        if (wr_en && wr_priv) begin
            root_d = wr_base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) root_q <= RESET_BASE;
        else        root_q <= root_d;
    end

    assign root_base = root_q;

    AST_ROOT_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> $stable(root_base)) else $error("root changed by unprivileged write"); // R11
endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
    import walk_pkg::*;
(
    input  logic [VPN_W-1:0]  vpn,
    input  logic [LVL_W-1:0]  level,
    input  logic [BASE_W-1:0] base,
    output logic [PA_W-1:0]   addr
);
    logic [IDX_W-1:0] slice [LEVELS];
    logic [IDX_W-1:0] idx;

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) idx = slice[i];
        end
        addr = {base, idx, {ENTRY_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/walk_entry_decode.sv
module walk_entry_decode
    import walk_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               acc_w_in,
    input  logic               acc_u_in,
    input  logic               want_write,
    input  logic               want_user,
    output entry_view_t        view,
    output logic               acc_w_out,
    output logic               acc_u_out,
    output logic               rights_ok
);
    logic unused_bits;
    assign unused_bits = ^{entry[ENTRY_W-1:BASE_LSB+BASE_W], entry[BASE_LSB-1:BIT_DIRTY+1],
                           entry[BIT_DIRTY-1:BIT_USER+1]};

    always_comb begin
        view.base     = entry[BASE_LSB +: BASE_W];
        view.present  = entry[BIT_PRESENT];
        view.writable = entry[BIT_WRITE];
        view.user_ok  = entry[BIT_USER];
        view.dirty    = entry[BIT_DIRTY];
        acc_w_out     = acc_w_in & view.writable;
        acc_u_out     = acc_u_in & view.user_ok;
        rights_ok     = !(want_write && !acc_w_out) && !(want_user && !acc_u_out);
    end
endmodule

// File: rtl/va_walk_engine.sv
module va_walk_engine
    import walk_pkg::*;
#(
    parameter logic [BASE_W-1:0] ROOT_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               root_wr_en,
    input  logic               root_wr_priv,
    input  logic [BASE_W-1:0]  root_wr_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic               req_write,
    input  logic               req_user,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    output logic               mem_rsp_ready,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [PA_W-1:0]    res_pa,
    output logic               res_writable,
    output logic               res_user,
    output logic               res_dirty,
    output logic               res_fault,
    output logic [LVL_W-1:0]   res_fault_level
);
    localparam logic [LVL_W-1:0] TOP_LEVEL = LVL_W'(LEVELS - 1);

    walk_regs_t  r_d, r_q;
    logic [BASE_W-1:0] root_base;
    entry_view_t view;
    logic acc_w_new, acc_u_new, rights_ok;

    walk_root_reg #(.RESET_BASE(ROOT_RESET)) u_root (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (root_wr_en),
        .wr_priv   (root_wr_priv),
        .wr_base   (root_wr_base),
        .root_base (root_base)
    );

    walk_addr_gen u_addr (
        .vpn   (r_q.va[VA_W-1:OFF_W]),
        .level (r_q.level),
        .base  (r_q.base),
        .addr  (mem_req_addr)
    );

    walk_entry_decode u_dec (
        .entry      (r_q.entry),
        .acc_w_in   (r_q.acc_w),
        .acc_u_in   (r_q.acc_u),
        .want_write (r_q.want_w),
        .want_user  (r_q.want_u),
        .view       (view),
        .acc_w_out  (acc_w_new),
        .acc_u_out  (acc_u_new),
        .rights_ok  (rights_ok)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va     = req_va;
                    r_d.want_w = req_write;
                    r_d.want_u = req_user;
                    r_d.base   = root_base;
                    r_d.level  = TOP_LEVEL;
                    r_d.acc_w  = 1'b1;
                    r_d.acc_u  = 1'b1;
                    r_d.pa     = '0;
                    r_d.dirty  = 1'b0;
                    r_d.flevel = '0;
                    r_d.state  = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_req_ready) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.entry = mem_rsp_data;
                    r_d.state = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (!view.present) begin
                    r_d.flevel = r_q.level;
                    r_d.state  = ST_FAULT;
                end else begin
                    r_d.acc_w = acc_w_new;
                    r_d.acc_u = acc_u_new;
                    if (r_q.level == '0) begin
                        if (rights_ok) begin
                            r_d.pa    = {view.base, r_q.va[OFF_W-1:0]};
                            r_d.dirty = view.dirty;
                            r_d.state = ST_DONE;
                        end else begin
                            r_d.flevel = '0;
                            r_d.state  = ST_FAULT;
                        end
                    end else begin
                        r_d.base  = view.base;
                        r_d.level = r_q.level - 1'b1;
                        r_d.state = ST_READ;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                if (res_ready) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.acc_w  <= 1'b1;
            r_q.acc_u  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready       = (r_q.state == ST_IDLE);
    assign mem_req_valid   = (r_q.state == ST_READ);
    assign mem_rsp_ready   = (r_q.state == ST_WAIT);
    assign res_valid       = (r_q.state == ST_DONE) || (r_q.state == ST_FAULT);
    assign res_fault       = (r_q.state == ST_FAULT);
    assign res_pa          = r_q.pa;
    assign res_writable    = r_q.acc_w;
    assign res_user        = r_q.acc_u;
    assign res_dirty       = r_q.dirty;
    assign res_fault_level = r_q.flevel;

    AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_req_valid) else $error("walk did not start"); // R2
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid) else $error("second read in flight"); // R3
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))) else $error("read dropped"); // R4
    AST_FAULT_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_fault_level <= TOP_LEVEL)) else $error("bad fault level"); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_fault)
                                       && $stable(res_fault_level))) else $error("result dropped"); // R9
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || mem_rsp_ready || res_valid) |-> !req_ready) else $error("accepting while busy"); // R10
endmodule

// File: tb/va_walk_engine_bench.sv
`timescale 1ns/1ps
module va_walk_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr_en = 1'b0, root_wr_priv = 1'b0;
    logic [39:0] root_wr_base = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic        req_ready;
    logic [56:0] req_va = '0;
    logic        mem_req_valid, mem_rsp_ready;
    logic        mem_req_ready = 1'b1;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid, res_writable, res_user, res_dirty, res_fault;
    logic        res_ready = 1'b0;
    logic [51:0] res_pa;
    logic [2:0]  res_fault_level;

    always #2 clk = ~clk;

    va_walk_engine u_va_walk_engine (
        .clk(clk), .rst_n(rst_n),
        .root_wr_en(root_wr_en), .root_wr_priv(root_wr_priv), .root_wr_base(root_wr_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_pa(res_pa),
        .res_writable(res_writable), .res_user(res_user), .res_dirty(res_dirty),
        .res_fault(res_fault), .res_fault_level(res_fault_level)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    bit [63:0] mem_tbl [bit [51:0]];
    logic [51:0] rd_log [8];
    int   n_reads = 0;
    logic [51:0] exp_addr [5];
    bit   pres [5], pw [5], pu [5];
    bit   dleaf;
    bit   stall_en = 0;
    int   resp_delay = 0;

    int   cyc = 0, cd = 0;
    bit   rsp_fire = 0;
    logic [63:0] pend = '0;

    // memory model, driven on falling edges
    always @(negedge clk) begin
        cyc++;
        if (rsp_fire) begin mem_rsp_valid = 1'b0; rsp_fire = 0; end
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pend; end
        end
        if (mem_rsp_valid && mem_rsp_ready) rsp_fire = 1;
        mem_req_ready = stall_en ? ((cyc % 4) >= 2) : 1'b1;
        if (mem_req_valid && mem_req_ready && cd == 0 && !mem_rsp_valid) begin
            if (n_reads < 8) rd_log[n_reads] = mem_req_addr;
            n_reads++;
            pend = mem_tbl.exists(mem_req_addr) ? mem_tbl[mem_req_addr] : 64'h0;
            cd = resp_delay + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic flags_all_set();
        for (int i = 0; i < 5; i++) begin pres[i] = 1; pw[i] = 1; pu[i] = 1; end
        dleaf = 0;
    endtask

    function automatic logic [63:0] mk_entry(input logic [39:0] nxt, input bit p, input bit w,
                                             input bit u, input bit d);
        logic [63:0] e;
        e = 64'(nxt) << 12;
        e[0] = p; e[1] = w; e[2] = u; e[6] = d;
        return e;
    endfunction

    // builds a table chain for va; read order index 0 is tier 4
    task automatic plant(input logic [56:0] va, input logic [39:0] root, input int salt,
                         output logic [39:0] frame);
        logic [39:0] tb [5];
        mem_tbl.delete();
        frame = 40'hA_0000 + 40'(salt);
        tb[4] = root;
        for (int l = 3; l >= 0; l--) tb[l] = 40'h1000 + 40'(salt * 16 + l);
        for (int l = 4; l >= 0; l--) begin
            logic [51:0] a;
            logic [39:0] nxt;
            nxt = (l == 0) ? frame : tb[l-1];
            a = {tb[l], va[12 + 9*l +: 9], 3'b000};
            mem_tbl[a] = mk_entry(nxt, pres[l], pw[l], pu[l], (l == 0) ? dleaf : 1'b0);
            exp_addr[4-l] = a;
        end
    endtask

    task automatic write_root(input logic [39:0] b, input bit priv);
        @(negedge clk);
        root_wr_en = 1'b1; root_wr_priv = priv; root_wr_base = b;
        @(negedge clk);
        root_wr_en = 1'b0; root_wr_priv = 1'b0;
    endtask

    task automatic run_walk(input logic [56:0] va, input bit ww, input bit uu,
                            input bit exp_fault, input logic [2:0] exp_lvl, input int exp_reads,
                            input bit exp_w, input bit exp_u, input bit exp_d,
                            input logic [39:0] frame, input int hold, input bit poke,
                            input string req);
        logic [51:0] first_pa;
        int guard;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n_reads = 0;
        req_va = va; req_write = ww; req_user = uu; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_va = ~va; req_write = 1'b1; req_user = 1'b1; req_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                chk("R10", "req_ready mid-walk", 64'(req_ready), 64'd0);
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        guard = 0;
        while (!res_valid && guard < 2000) begin @(negedge clk); guard++; end
        if (hold > 0) begin
            first_pa = res_pa;
            repeat (hold) @(negedge clk);
            chk("R9", "res_valid held", 64'(res_valid), 64'd1);
            chk("R9", "res_pa held", 64'(res_pa), 64'(first_pa));
        end
        chk(req, "res_fault", 64'(res_fault), 64'(exp_fault));
        if (exp_fault) begin
            chk(req, "fault level", 64'(res_fault_level), 64'(exp_lvl));
        end else begin
            chk("R8", "res_pa", 64'(res_pa), 64'({frame, va[11:0]}));
            chk(req, "res_writable", 64'(res_writable), 64'(exp_w));
            chk(req, "res_user", 64'(res_user), 64'(exp_u));
            chk("R8", "res_dirty", 64'(res_dirty), 64'(exp_d));
        end
        chk("R3", "read count", 64'(n_reads), 64'(exp_reads));
        for (int i = 0; i < exp_reads && i < 5; i++)
            chk("R2", "read address", 64'(rd_log[i]), 64'(exp_addr[i]));
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R9", "req_ready after accept", 64'(req_ready), 64'd1);
        chk("R9", "res_valid after accept", 64'(res_valid), 64'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "res_valid", 64'(res_valid), 64'd0);
    endtask

    task automatic t_basic();
        logic [39:0] fr;
        logic [56:0] va = 57'h1_2345_6789_ABCD_E;
        flags_all_set(); dleaf = 1;
        plant(va, 40'h111, 1, fr);
        run_walk(va, 1, 1, 0, 0, 5, 1, 1, 1, fr, 0, 0, "R8");
    endtask

    task automatic t_stall();
        logic [39:0] fr;
        logic [56:0] va = 57'h0_F0E1_D2C3_B4A5_9;
        flags_all_set();
        stall_en = 1; resp_delay = 3;
        plant(va, 40'h111, 2, fr);
        run_walk(va, 0, 0, 0, 0, 5, 1, 1, 0, fr, 3, 0, "R4");
        stall_en = 0; resp_delay = 0;
    endtask

    task automatic t_absent();
        logic [39:0] fr;
        logic [56:0] va = 57'h1_FFFF_0000_1234_5;
        flags_all_set(); pres[2] = 0;
        plant(va, 40'h111, 3, fr);
        run_walk(va, 0, 0, 1, 3'd2, 3, 0, 0, 0, fr, 0, 0, "R5");
        flags_all_set(); pres[4] = 0;
        plant(va, 40'h111, 4, fr);
        run_walk(va, 0, 0, 1, 3'd4, 1, 0, 0, 0, fr, 0, 0, "R5");
    endtask

    task automatic t_readonly();
        logic [39:0] fr;
        logic [56:0] va = 57'h0_0420_0810_2040_8;
        flags_all_set(); pw[3] = 0;
        plant(va, 40'h111, 5, fr);
        run_walk(va, 1, 0, 1, 3'd0, 5, 0, 0, 0, fr, 0, 0, "R6");
        run_walk(va, 0, 0, 0, 0, 5, 0, 1, 0, fr, 0, 0, "R6");
    endtask

    task automatic t_user();
        logic [39:0] fr;
        logic [56:0] va = 57'h1_5555_AAAA_3333_C;
        flags_all_set(); pu[1] = 0;
        plant(va, 40'h111, 6, fr);
        run_walk(va, 0, 1, 1, 3'd0, 5, 0, 0, 0, fr, 0, 0, "R7");
        run_walk(va, 0, 0, 0, 0, 5, 1, 0, 0, fr, 0, 0, "R7");
    endtask

    task automatic t_busy();
        logic [39:0] fr;
        logic [56:0] va = 57'h0_7777_1111_8888_2;
        flags_all_set();
        plant(va, 40'h111, 7, fr);
        run_walk(va, 0, 0, 0, 0, 5, 1, 1, 0, fr, 0, 1, "R10");
    endtask

    task automatic t_root();
        logic [39:0] fr;
        logic [56:0] va = 57'h1_0101_2020_3030_4;
        flags_all_set();
        write_root(40'h999, 0);
        plant(va, 40'h111, 8, fr);
        run_walk(va, 0, 0, 0, 0, 5, 1, 1, 0, fr, 0, 0, "R11");
        write_root(40'h222, 1);
        plant(va, 40'h222, 9, fr);
        run_walk(va, 0, 0, 0, 0, 5, 1, 1, 0, fr, 0, 0, "R11");
    endtask

    initial begin
        t_reset();
        write_root(40'h111, 1);
        t_basic();
        t_stall();
        t_absent();
        t_readonly();
        t_user();
        t_busy();
        t_root();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule